// File: doc/BRIEF.md
# Comparator Task/Event Controller

This block is the digital control wrapper for a one-bit level comparator. Software drives it through a small register port. Writes to three task offsets start the comparator, stop it, or capture its present output. After a start, the block counts a fixed start-up interval and then raises a ready flag. From that point it watches the comparator bit and records upward and downward transitions as sticky event flags. Each transition also sets a shared crossing flag.

The comparator bit arrives asynchronously. It passes through a two-stage synchronizer before edges are detected. Five shortcut bits let an event stop the comparator or capture a sample in the same cycle the event fires, with no software involved. An interrupt-enable mask, with separate set and clear offsets, gates the pending flags onto one interrupt line. A wake output pulses on crossings of a selectable direction. When the chip is in its off mode, a crossing produces only the wake pulse and sets no flags.

Top module: `lvlcmp_top`

## Requirements
- R1: After reset, all event flags, the interrupt mask, the shortcut bits, the enable bit, the wake mode and the result bit are 0, and both `irq` and `wake_det` are low.
- R2: Writing 1 to offset 0x000 while enabled (offset 0x500 bit 0 = 1) sets the ready flag (offset 0x100) exactly STARTUP_CYC clock edges after the write edge. A start while disabled is ignored.
- R3: While running, a 0→1 change of the synchronized comparator sets the up flag (0x108) and the crossing flag (0x10C), and a 1→0 change sets the down flag (0x104) and the crossing flag. Each flag appears on the third rising edge after the input changes. Changes during the start-up interval or after a stop (write 1 to 0x004) set no flag.
- R4: An event flag stays at 1 until a write with bit 0 = 0 to its own offset. A write with bit 0 = 1 leaves it unchanged.
- R5: Writing 1 to offset 0x008 while enabled copies the synchronized comparator level into bit 0 of offset 0x400 (1 = above the reference).
- R6: The shortcut register at 0x200 has these bits. Bit 0: ready triggers a sample. Bit 1: ready triggers a stop. Bit 2: a down event triggers a stop. Bit 3: an up event triggers a stop. Bit 4: a crossing event triggers a stop. Each acts in the same cycle as its event.
- R7: The interrupt mask bits are bit 0 ready, bit 1 down, bit 2 up and bit 3 cross. A 1 written at 0x304 sets a bit and a 1 written at 0x308 clears it. 0 bits have no effect. Both offsets read back the mask.
- R8: `irq` is high exactly when some event flag is both pending and enabled in the mask.
- R9: Bits [1:0] at offset 0x510 select the wake mode. 0 pulses `wake_det` for one cycle on any crossing, 1 on upward crossings only, 2 on downward crossings only, and 3 never. The pulse is coincident with the event flags.
- R10: While `sys_off` is high, no event flag is set, but crossings still produce the wake pulse.
- R11: Clearing the enable bit stops the comparator; later crossings set no flag until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Asynchronous comparator output |
| sys_off | input | 1 | Chip is in the low-power off mode |
| irq | output | 1 | Interrupt request |
| wake_det | output | 1 | One-cycle wake-detect pulse |

## Verification
The hardest situations to reach from the ports are the stop shortcuts. In these, the event that causes the stop must be recorded while the edge right after it is dropped. The bench enables one shortcut at a time and drives the triggering edge. It then drives the opposite edge and confirms that the flag for that second edge stays clear. Edges during the start-up window are reached by toggling the input right after a start, well before the interval ends. The off-mode path is reached by raising `sys_off` while the block is running. A counter on `wake_det` then shows the pulse appearing with no flag set.

// File: rtl/lvlcmp_pkg.sv
package lvlcmp_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WARM, ST_RUN} run_st_e;

    localparam int NEV = 4;
    localparam int NSC = 5;
    localparam int EV_RDY = 0;
    localparam int EV_DN  = 1;
    localparam int EV_UP  = 2;
    localparam int EV_CR  = 3;

    localparam int SC_RDY_SMP = 0;
    localparam int SC_RDY_STP = 1;
    localparam int SC_DN_STP  = 2;
    localparam int SC_UP_STP  = 3;
    localparam int SC_CR_STP  = 4;

    localparam logic [1:0] WM_ANY = 2'd0;
    localparam logic [1:0] WM_UP  = 2'd1;
    localparam logic [1:0] WM_DN  = 2'd2;

    localparam logic [11:0] A_START  = 12'h000;
    localparam logic [11:0] A_STOP   = 12'h004;
    localparam logic [11:0] A_SAMPLE = 12'h008;
    localparam logic [11:0] A_EVBASE = 12'h100;
    localparam logic [11:0] A_SHORT  = 12'h200;
    localparam logic [11:0] A_IESET  = 12'h304;
    localparam logic [11:0] A_IECLR  = 12'h308;
    localparam logic [11:0] A_RESULT = 12'h400;
    localparam logic [11:0] A_ENABLE = 12'h500;
    localparam logic [11:0] A_WMODE  = 12'h510;

    typedef struct packed {
        logic [NSC-1:0] sc;
        logic [NEV-1:0] ie;
        logic           en;
        logic [1:0]     wm;
    } regs_t;
endpackage

// File: rtl/lvlcmp_sync.sv
module lvlcmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/lvlcmp_core.sv
module lvlcmp_core
    import lvlcmp_pkg::*;
#(
    parameter int STARTUP_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           sys_off,
    input  logic           task_start,
    input  logic           task_stop,
    input  logic           task_sample,
    input  logic [NEV-1:0] ev_clr,
    input  logic [NSC-1:0] shorts,
    input  logic [1:0]     wake_mode,
    input  logic           lvl,
    input  logic           rise,
    input  logic           fall,
    output logic [NEV-1:0] ev,
    output logic           result,
    output logic           wake
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

    typedef struct packed {
        run_st_e        st;
        logic [CW-1:0]  cnt;
        logic [NEV-1:0] ev;
        logic           res;
        logic           wake;
    } core_t;

    core_t q, d;
    logic [NEV-1:0] raw, set;
    logic sc_stop, smp, hit;

    always_comb begin
        d       = q;
        d.wake  = 1'b0;
        raw     = '0;
        hit     = 1'b0;
        case (q.st)
            ST_IDLE: if (task_start && enable) begin
                d.st  = ST_WARM;
                d.cnt = '0;
            end
            ST_WARM: begin
                if (q.cnt == LAST) begin
                    d.st        = ST_RUN;
                    raw[EV_RDY] = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                raw[EV_UP] = rise;
                raw[EV_DN] = fall;
                raw[EV_CR] = rise | fall;
                case (wake_mode)
                    WM_ANY:  hit = rise | fall;
                    WM_UP:   hit = rise;
                    WM_DN:   hit = fall;
                    default: hit = 1'b0;
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
        d.wake  = hit;
        set     = sys_off ? '0 : raw;
        sc_stop = (set[EV_RDY] & shorts[SC_RDY_STP]) | (set[EV_DN] & shorts[SC_DN_STP])
                | (set[EV_UP] & shorts[SC_UP_STP]) | (set[EV_CR] & shorts[SC_CR_STP]);
        smp     = (task_sample && enable) || (set[EV_RDY] && shorts[SC_RDY_SMP]);
        if (smp) d.res = lvl;
        if (task_stop || !enable || sc_stop) d.st = ST_IDLE;
        d.ev = (q.ev & ~ev_clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, ev: '0, res: 1'b0, wake: 1'b0};
        else        q <= d;
    end

    assign ev     = q.ev;
    assign result = q.res;
    assign wake   = q.wake;

    p_ready_warm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ev[EV_RDY]) |-> $past(q.st) == ST_WARM);
    p_up_from_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ev[EV_UP]) |-> ($past(rise) && q.ev[EV_CR]));
    p_dn_from_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ev[EV_DN]) |-> ($past(fall) && q.ev[EV_CR]));
    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sys_off) |-> ((q.ev & ~$past(q.ev)) == '0));
    p_wake_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.wake |-> ($past(q.st) == ST_RUN));
endmodule

// File: rtl/lvlcmp_top.sv
module lvlcmp_top
    import lvlcmp_pkg::*;
#(
    parameter int STARTUP_CYC = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cmp_in,
    input  logic        sys_off,
    output logic        irq,
    output logic        wake_det
);
    regs_t r_q, r_d;
    logic [NEV-1:0] ev, ev_clr;
    logic lvl, rise, fall, result;
    logic t_start, t_stop, t_sample;

    assign t_start  = bus_wr && bus_addr == A_START  && bus_wdata[0];
    assign t_stop   = bus_wr && bus_addr == A_STOP   && bus_wdata[0];
    assign t_sample = bus_wr && bus_addr == A_SAMPLE && bus_wdata[0];

    for (genvar i = 0; i < NEV; i++) begin : g_evclr
        assign ev_clr[i] = bus_wr && !bus_wdata[0] && bus_addr == A_EVBASE + 12'(4 * i);
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_SHORT:  r_d.sc = bus_wdata[NSC-1:0];
                A_IESET:  r_d.ie = r_q.ie | bus_wdata[NEV-1:0];
                A_IECLR:  r_d.ie = r_q.ie & ~bus_wdata[NEV-1:0];
                A_ENABLE: r_d.en = bus_wdata[0];
                A_WMODE:  r_d.wm = bus_wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SHORT:           bus_rdata[NSC-1:0] = r_q.sc;
            A_IESET, A_IECLR:  bus_rdata[NEV-1:0] = r_q.ie;
            A_RESULT:          bus_rdata[0]       = result;
            A_ENABLE:          bus_rdata[0]       = r_q.en;
            A_WMODE:           bus_rdata[1:0]     = r_q.wm;
            default: begin
                for (int i = 0; i < NEV; i++)
                    if (bus_addr == A_EVBASE + 12'(4 * i)) bus_rdata[0] = ev[i];
            end
        endcase
    end

    assign irq = |(ev & r_q.ie);

    lvlcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    lvlcmp_core #(.STARTUP_CYC(STARTUP_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(r_q.en), .sys_off(sys_off),
        .task_start(t_start), .task_stop(t_stop), .task_sample(t_sample),
        .ev_clr(ev_clr), .shorts(r_q.sc), .wake_mode(r_q.wm),
        .lvl(lvl), .rise(rise), .fall(fall),
        .ev(ev), .result(result), .wake(wake_det)
    );

    p_ieclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == A_IECLR && bus_wdata[0]) |-> !r_q.ie[0]);
    p_ieset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == A_IESET && bus_wdata[0]) |-> r_q.ie[0]);
endmodule

// File: tb/lvlcmp_top_tb.sv
`timescale 1ns/10ps
module lvlcmp_top_tb;
    localparam int S = 8;

    logic clk = 0, rst_n = 0, bus_wr = 0, cmp_in = 0, sys_off = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic irq, wake_det;
    int errs = 0, checks = 0, wake_cnt = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) if (wake_det) wake_cnt++;

    lvlcmp_top #(.STARTUP_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .sys_off(sys_off), .irq(irq), .wake_det(wake_det)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output int v);
        bus_addr = a; #0.1; v = int'(bus_rdata);
    endtask

    function automatic logic [11:0] eva(input int i);
        return 12'h100 + 12'(4 * i);
    endfunction

    task automatic evs(output int v);
        int b;
        v = 0;
        for (int i = 0; i < 4; i++) begin rd(eva(i), b); v |= (b & 1) << i; end
    endtask

    task automatic clr_all();
        for (int i = 0; i < 4; i++) wr(eva(i), 0);
    endtask

    task automatic restart();
        wr(12'h004, 1); clr_all(); wr(12'h000, 1); cyc(S); clr_all();
    endtask

    task automatic setin(input logic v);
        cmp_in = v; cyc(3);
    endtask

    initial begin
        int v, e, exp_w;
        cyc(2); rst_n = 1; cyc(1);
        // R1 reset state
        evs(v); chk("R1 events", v, 0);
        rd(12'h304, v); chk("R1 mask", v, 0);
        rd(12'h400, v); chk("R1 result", v, 0);
        rd(12'h200, v); chk("R1 shorts", v, 0);
        rd(12'h500, v); chk("R1 enable", v, 0);
        chk("R1 irq", irq, 0); chk("R1 wake", wake_det, 0);

        // R2 start while disabled is ignored
        wr(12'h000, 1); cyc(S + 2); evs(v); chk("R2 disabled start", v, 0);
        wr(12'h500, 1);
        wr(12'h000, 1); cyc(S - 1); rd(eva(0), v); chk("R2 ready early", v, 0);
        cyc(1); rd(eva(0), v); chk("R2 ready on time", v, 1);
        // R4 write 1 keeps, write 0 clears
        wr(eva(0), 1); rd(eva(0), v); chk("R4 write1 keeps", v, 1);
        wr(eva(0), 0); rd(eva(0), v); chk("R4 write0 clears", v, 0);

        // R3 and R9 sweep over wake modes and both directions
        for (int m = 0; m < 4; m++) begin
            wr(12'h510, m);
            wake_cnt = 0;
            cmp_in = 1; cyc(2); evs(v); chk("R3 rise latency", v, 0);
            cyc(1); evs(v); chk("R3 rise flags", v, 4'b1100);
            cyc(1); exp_w = (m == 0 || m == 1) ? 1 : 0;
            chk("R9 wake on rise", wake_cnt, exp_w);
            clr_all(); wake_cnt = 0;
            cmp_in = 0; cyc(2); evs(v); chk("R3 fall latency", v, 0);
            cyc(1); evs(v); chk("R3 fall flags", v, 4'b1010);
            cyc(1); exp_w = (m == 0 || m == 2) ? 1 : 0;
            chk("R9 wake on fall", wake_cnt, exp_w);
            clr_all();
        end
        wr(12'h510, 0);

        // R5 sample both levels
        setin(1); wr(12'h008, 1); rd(12'h400, v); chk("R5 sample high", v, 1);
        setin(0); wr(12'h008, 1); rd(12'h400, v); chk("R5 sample low", v, 0);
        clr_all();

        // R7/R8 mask sweep with two pending patterns
        wr(12'h000, 1);  // already running: no effect
        setin(1); setin(0); wr(eva(0), 1);
        restart(); setin(1); setin(0);
        // pending now: down, up, cross; set ready by a fresh start
        wr(12'h004, 1); wr(12'h000, 1); cyc(S);
        for (int p = 0; p < 2; p++) begin
            evs(e);
            chk("R8 pending pattern", e, p == 0 ? 15 : 9);
            for (int m = 0; m < 16; m++) begin
                wr(12'h308, 15); wr(12'h304, m);
                wr(12'h304, 0); wr(12'h308, 0);
                rd(12'h304, v); chk("R7 set readback", v, m);
                rd(12'h308, v); chk("R7 clr readback", v, m);
                chk("R8 irq", irq, ((m & e) != 0) ? 1 : 0);
            end
            wr(eva(1), 0); wr(eva(2), 0);
        end
        wr(12'h308, 15); clr_all();

        // R6 crossing->stop, up->stop, down->stop
        restart(); wr(12'h200, 5'b10000);
        setin(1); evs(v); chk("R6 cross stop first", v, 4'b1100);
        clr_all(); setin(0); evs(v); chk("R6 cross stop after", v, 0);
        restart(); wr(12'h200, 5'b01000);
        setin(1); clr_all(); setin(0); evs(v); chk("R6 up stop after", v, 0);
        wr(12'h200, 0); restart(); setin(1); clr_all();
        wr(12'h200, 5'b00100);
        setin(0); evs(v); chk("R6 down stop first", v, 4'b1010);
        clr_all(); setin(1); evs(v); chk("R6 down stop after", v, 0);
        setin(0);
        // R6 ready->stop
        wr(12'h200, 5'b00010); restart();
        setin(1); evs(v); chk("R6 ready stop", v, 0);
        // R6 ready->sample
        wr(12'h200, 0); setin(0); wr(12'h008, 1); setin(1);
        wr(12'h200, 5'b00001); wr(12'h004, 1); wr(12'h000, 1); cyc(S);
        rd(12'h400, v); chk("R6 ready sample", v, 1);
        wr(12'h200, 0); setin(0); clr_all();

        // R3 edges during start-up are ignored
        wr(12'h004, 1); wr(12'h000, 1); setin(1); cyc(S);
        evs(v); chk("R3 warm ignored", v, 1);
        clr_all(); setin(0); clr_all();

        // R10 off mode: wake only
        sys_off = 1; wake_cnt = 0;
        setin(1); cyc(1); evs(v); chk("R10 no flags", v, 0);
        chk("R10 wake", wake_cnt, 1);
        sys_off = 0; setin(0); clr_all();

        // R11 disable stops
        wr(12'h500, 0); setin(1); evs(v); chk("R11 disabled", v, 0);
        wr(12'h500, 1); setin(0); evs(v); chk("R11 still stopped", v, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule